// File: doc/BRIEF.md
# Autocorrelation Packet Detector

This block watches a stream of complex baseband samples at the front of an OFDM receiver and decides whether a packet preamble is present. The short training part of a preamble repeats every 16 samples, so each new sample is multiplied by the complex conjugate of the sample 16 positions earlier. The products are summed over a sliding 16-sample window into a correlation P. The power of the incoming samples is summed over the same window into an energy R. A packet is declared when the normalised metric |P|²/R² reaches a programmable threshold. The division is never formed: the block compares cross-multiplied terms.

A controller pulses `arm` to start a search. The detector clears its history and lets its delay lines fill. It then tests the metric once per sample and raises `pkt_found` for one cycle once the condition has held for `hold_len` samples in a row. After reporting, it goes idle until it is armed again. One sample is taken per clock while searching. Samples are 5-bit signed I and Q values, taken from the upper bits of the converter output.

Top module: `pkt_acorr_detect`

## Requirements
- R1: After reset, and at any time when no search has been started, `pkt_found` stays low whatever samples arrive.
- R2: A pulse on `arm` starts a new search and clears all history. The sample presented in the `arm` cycle and every earlier sample have no effect. Samples taken after `arm` see zeros wherever the history would reach back before the start of the search.
- R3: For sample index n (0 is the first sample after `arm`), P(n) is the sum, for k = n-15 to n, of x(k)·conj(x(k-16)). R(n) is the sum of re²+im² of x(k) over the same k.
- R4: A sample is a hit when 4·|P|² ≥ thres·R², with `thres` read as an unsigned 4-bit integer. The threshold ratio is therefore thres/4.
- R5: A sample whose window energy R is zero is never a hit, whatever the threshold.
- R6: Samples with index 0 to 31 after `arm` are never evaluated. Index 32 is the first sample that can be a hit.
- R7: `pkt_found` rises when the run of consecutive hits reaches `hold_len`, read as an unsigned integer in which 0 counts as 1. A sample that is evaluated and is not a hit resets the run to zero.
- R8: `pkt_found` is high for exactly one cycle. The detector then stays idle and reports nothing more until the next `arm`.
- R9: `pkt_found` goes high at the first rising edge after the edge that captures the sample completing the run. With a perfectly periodic input, thres=4 and hold_len=3, this is the 36th rising edge after the `arm` edge.
- R10: An `arm` pulse during a search restarts it from sample index 0. The earlier partial search has no effect on when the result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle while searching |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse that starts or restarts a search |
| in_re | input | 5 | Sample in-phase part, signed |
| in_im | input | 5 | Sample quadrature part, signed |
| thres | input | 4 | Metric threshold in units of 1/4 |
| hold_len | input | 4 | Consecutive hits required (0 counts as 1) |
| pkt_found | output | 1 | One-cycle packet-found pulse |

## Verification
Any corrupt internal state eventually appears on `pkt_found`. A stale delay-line tap or a running sum that drifts after a bad subtraction moves P or R away from their true values. Such a fault never corrects itself, so it shifts, adds or suppresses the found pulse. The bench compares `pkt_found` every cycle against a model that recomputes both window sums directly from the sample history. A bad tap is seen within 16 to 32 samples of first being used. A miscounted fill or run length is seen as a found pulse one or more edges away from the expected edge.

// File: rtl/pkt_acd_pkg.sv
package pkt_acd_pkg;
    localparam int SMP_W      = 5;
    localparam int LAG        = 16;
    localparam int LAG_LOG    = $clog2(LAG);
    localparam int EVAL_START = 2 * LAG;
    localparam int PRD_W      = 2 * SMP_W + 1;
    localparam int PSUM_W     = PRD_W + LAG_LOG;
    localparam int EN_W       = 2 * SMP_W;
    localparam int RSUM_W     = EN_W + LAG_LOG;
    localparam int PMAG_W     = 2 * PSUM_W;
    localparam int RSQ_W      = 2 * RSUM_W;
    localparam int R_MAX      = LAG * (2 ** (2 * SMP_W - 1));

    typedef struct packed {
        logic signed [SMP_W-1:0] re;
        logic signed [SMP_W-1:0] im;
    } smp_t;

    typedef struct packed {
        logic signed [PRD_W-1:0] re;
        logic signed [PRD_W-1:0] im;
    } prd_t;

    typedef struct packed {
        logic signed [PSUM_W-1:0] re;
        logic signed [PSUM_W-1:0] im;
    } acc_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_HUNT = 1'b1} hunt_st_t;

    // cur * conj(old)
    function automatic prd_t conj_mul(smp_t cur, smp_t old);
        logic signed [PRD_W-1:0] ar, ai, br, bi;
        prd_t res;
        ar = PRD_W'(cur.re);
        ai = PRD_W'(cur.im);
        br = PRD_W'(old.re);
        bi = PRD_W'(old.im);
        res.re = ar * br + ai * bi;
        res.im = ai * br - ar * bi;
        return res;
    endfunction

    function automatic logic [EN_W-1:0] smp_pwr(smp_t s);
        logic signed [EN_W:0] sr, si, tot;
        sr  = (EN_W+1)'(s.re);
        si  = (EN_W+1)'(s.im);
        tot = sr * sr + si * si;
        return tot[EN_W-1:0];
    endfunction
endpackage

// File: rtl/acd_lag_line.sv
module acd_lag_line #(
    parameter int W     = 10,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         sh_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] tap [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int k = 0; k < DEPTH; k++) tap[k] <= '0;
        end else if (sh_en) begin
            tap[0] <= din;
            for (int k = 1; k < DEPTH; k++) tap[k] <= tap[k-1];
        end
    end

    // oldest entry: the value shifted in DEPTH edges ago
    assign dout = tap[DEPTH-1];
endmodule

// File: rtl/acd_corr_accum.sv
module acd_corr_accum
    import pkt_acd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  smp_t              x_new,
    output acc_t              psum,
    output logic [RSUM_W-1:0] rsum
);
    smp_t             x_old;
    prd_t             c_new;
    prd_t             c_old;
    logic [EN_W-1:0]  e_new;
    logic [EN_W-1:0]  e_old;

    acd_lag_line #(.W(2*SMP_W), .DEPTH(LAG)) u_smp_line (
        .clk(clk), .rst(rst), .clr(clr), .sh_en(en),
        .din(x_new), .dout(x_old)
    );

    assign c_new = conj_mul(x_new, x_old);
    assign e_new = smp_pwr(x_new);
    assign e_old = smp_pwr(x_old);

    acd_lag_line #(.W(2*PRD_W), .DEPTH(LAG)) u_prd_line (
        .clk(clk), .rst(rst), .clr(clr), .sh_en(en),
        .din(c_new), .dout(c_old)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            psum <= '0;
            rsum <= '0;
        end else if (en) begin
            psum.re <= psum.re + PSUM_W'(c_new.re) - PSUM_W'(c_old.re);
            psum.im <= psum.im + PSUM_W'(c_new.im) - PSUM_W'(c_old.im);
            rsum    <= rsum + RSUM_W'(e_new) - RSUM_W'(e_old);
        end
    end

    assert_clear_on_arm_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (psum == '0 && rsum == '0));

    assert_energy_bound_R3: assert property (@(posedge clk) disable iff (rst)
        rsum <= RSUM_W'(R_MAX));
endmodule

// File: rtl/acd_metric_cmp.sv
module acd_metric_cmp
    import pkt_acd_pkg::*;
#(
    parameter int THR_W  = 4,
    parameter int PSHIFT = 2
) (
    input  acc_t              psum,
    input  logic [RSUM_W-1:0] rsum,
    input  logic [THR_W-1:0]  thres,
    output logic              hit
);
    localparam int LHS_W = PMAG_W + PSHIFT;
    localparam int RHS_W = THR_W + RSQ_W;
    localparam int CMP_W = (LHS_W > RHS_W) ? LHS_W : RHS_W;

    logic signed [PMAG_W-1:0] pr_x, pi_x;
    logic [PMAG_W-1:0]        pmag;
    logic [RSQ_W-1:0]         rsq;
    logic [CMP_W-1:0]         lhs, rhs;

    always_comb begin
        pr_x = PMAG_W'(psum.re);
        pi_x = PMAG_W'(psum.im);
        pmag = $unsigned(pr_x * pr_x + pi_x * pi_x);
        rsq  = RSQ_W'(rsum) * RSQ_W'(rsum);
        lhs  = CMP_W'(pmag) << PSHIFT;
        rhs  = CMP_W'(thres) * CMP_W'(rsq);
        hit  = (rsum != '0) && (lhs >= rhs);
    end
endmodule

// File: rtl/acd_hunt_ctrl.sv
module acd_hunt_ctrl
    import pkt_acd_pkg::*;
#(
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             hit,
    input  logic [RUN_W-1:0] hold_len,
    output logic             shift_en,
    output logic             eval_vld,
    output logic             found
);
    localparam int CNT_W = $clog2(EVAL_START + 2);

    hunt_st_t         st;
    logic [CNT_W-1:0] smp_cnt;
    logic [RUN_W-1:0] run;
    logic [RUN_W:0]   run_nxt;
    logic [RUN_W:0]   hold_eff;

    assign hold_eff = (hold_len == '0) ? (RUN_W+1)'(1) : {1'b0, hold_len};
    assign run_nxt  = {1'b0, run} + 1'b1;
    assign shift_en = (st == ST_HUNT) && !arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            smp_cnt  <= '0;
            run      <= '0;
            eval_vld <= 1'b0;
            found    <= 1'b0;
        end else if (arm) begin
            st       <= ST_HUNT;
            smp_cnt  <= '0;
            run      <= '0;
            eval_vld <= 1'b0;
            found    <= 1'b0;
        end else begin
            found <= 1'b0;
            if (st == ST_HUNT) begin
                eval_vld <= (smp_cnt >= CNT_W'(EVAL_START));
                if (smp_cnt <= CNT_W'(EVAL_START)) smp_cnt <= smp_cnt + 1'b1;
            end else begin
                eval_vld <= 1'b0;
            end
            if (eval_vld) begin
                if (hit) begin
                    if (run_nxt >= hold_eff) begin
                        found    <= 1'b1;
                        st       <= ST_IDLE;
                        eval_vld <= 1'b0;
                        run      <= '0;
                    end else begin
                        run <= run_nxt[RUN_W-1:0];
                    end
                end else begin
                    run <= '0;
                end
            end
        end
    end

    assert_found_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        found |=> !found);

    assert_skip_fill_R6: assert property (@(posedge clk) disable iff (rst)
        eval_vld |-> (smp_cnt > CNT_W'(EVAL_START)));
endmodule

// File: rtl/pkt_acorr_detect.sv
module pkt_acorr_detect
    import pkt_acd_pkg::*;
#(
    parameter int THR_W  = 4,
    parameter int RUN_W  = 4,
    parameter int PSHIFT = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    arm,
    input  logic signed [SMP_W-1:0] in_re,
    input  logic signed [SMP_W-1:0] in_im,
    input  logic [THR_W-1:0]        thres,
    input  logic [RUN_W-1:0]        hold_len,
    output logic                    pkt_found
);
    smp_t              x_new;
    acc_t              psum;
    logic [RSUM_W-1:0] rsum;
    logic              shift_en;
    logic              eval_vld;
    logic              hit;

    assign x_new.re = in_re;
    assign x_new.im = in_im;

    acd_corr_accum u_accum (
        .clk(clk), .rst(rst), .clr(arm), .en(shift_en),
        .x_new(x_new), .psum(psum), .rsum(rsum)
    );

    acd_metric_cmp #(.THR_W(THR_W), .PSHIFT(PSHIFT)) u_cmp (
        .psum(psum), .rsum(rsum), .thres(thres), .hit(hit)
    );

    acd_hunt_ctrl #(.RUN_W(RUN_W)) u_ctrl (
        .clk(clk), .rst(rst), .arm(arm), .hit(hit), .hold_len(hold_len),
        .shift_en(shift_en), .eval_vld(eval_vld), .found(pkt_found)
    );

    assert_found_after_hit_R7: assert property (@(posedge clk) disable iff (rst)
        pkt_found |-> ($past(hit) && $past(eval_vld)));
endmodule

// File: tb/pkt_acorr_detect_tb_top.sv
module pkt_acorr_detect_tb_top;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              arm = 1'b0;
    logic signed [4:0] in_re = '0;
    logic signed [4:0] in_im = '0;
    logic [3:0]        thres = '0;
    logic [3:0]        hold_len = '0;
    logic              pkt_found;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    pkt_acorr_detect dut_i (
        .clk(clk), .rst(rst), .arm(arm), .in_re(in_re), .in_im(in_im),
        .thres(thres), .hold_len(hold_len), .pkt_found(pkt_found)
    );

    always #4 clk = ~clk;

    // reference model state
    int      sx_re[32];
    int      sx_im[32];
    bit      m_active, m_s1, m_found;
    int      m_n, m_run;
    longint  m_pre, m_pim, m_r;
    int      thr, hold;
    int      edge_cnt;
    int      found_at;
    int      found_num;
    string   cur_req = "R1";
    int      pat_re[16];
    int      pat_im[16];

    function automatic bit exp_hit(longint pre, longint pim, longint r, int th);
        longint lhs, rhs;
        lhs = (pre * pre + pim * pim) * 4;
        rhs = longint'(th) * r * r;
        return (r != 0) && (lhs >= rhs);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_edge(bit a, int re, int im);
        bit n_found = 0;
        bit n_active = m_active;
        bit n_s1 = 0;
        int n_run = m_run;
        int heff = (hold == 0) ? 1 : hold;
        if (a) begin
            for (int k = 0; k < 32; k++) begin sx_re[k] = 0; sx_im[k] = 0; end
            m_active = 1; m_n = 0; m_s1 = 0; m_run = 0; m_found = 0;
            m_pre = 0; m_pim = 0; m_r = 0;
            return;
        end
        if (m_s1) begin
            if (exp_hit(m_pre, m_pim, m_r, thr)) begin
                if (m_run + 1 >= heff) begin
                    n_found = 1; n_active = 0; n_run = 0;
                end else n_run = m_run + 1;
            end else n_run = 0;
        end
        if (m_active) begin
            for (int k = 31; k > 0; k--) begin
                sx_re[k] = sx_re[k-1]; sx_im[k] = sx_im[k-1];
            end
            sx_re[0] = re; sx_im[0] = im;
            m_pre = 0; m_pim = 0; m_r = 0;
            for (int k = 0; k < 16; k++) begin
                m_pre += sx_re[k] * sx_re[k+16] + sx_im[k] * sx_im[k+16];
                m_pim += sx_im[k] * sx_re[k+16] - sx_re[k] * sx_im[k+16];
                m_r   += sx_re[k] * sx_re[k] + sx_im[k] * sx_im[k];
            end
            n_s1 = (m_n >= 32);
            if (m_n <= 32) m_n++;
        end
        if (n_found) n_s1 = 0;
        m_active = n_active; m_s1 = n_s1; m_run = n_run; m_found = n_found;
    endtask

    task automatic step(bit a, int re, int im);
        @(negedge clk);
        chk(pkt_found === m_found, cur_req, pkt_found, m_found);
        if (pkt_found === 1'b1) begin
            found_at = edge_cnt;
            found_num++;
        end
        arm = a; in_re = 5'(re); in_im = 5'(im);
        thres = 4'(thr); hold_len = 4'(hold);
        model_edge(a, re, im);
        if (a) edge_cnt = 0; else edge_cnt++;
    endtask

    function automatic int rnd_s();
        return int'($urandom_range(31)) - 16;
    endfunction

    task automatic new_pattern();
        for (int k = 0; k < 16; k++) begin
            pat_re[k] = rnd_s(); pat_im[k] = rnd_s();
        end
        pat_re[0] = 7; pat_im[0] = -3;
    endtask

    task automatic start_search(int t, int h);
        thr = t; hold = h;
        found_at = -1; found_num = 0;
        step(1, rnd_s(), rnd_s());
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_active = 0; m_s1 = 0; m_found = 0; m_n = 0; m_run = 0;
        m_pre = 0; m_pim = 0; m_r = 0; thr = 0; hold = 1; edge_cnt = 0;
        repeat (3) @(negedge clk);
        chk(pkt_found === 1'b0, "R1 reset", pkt_found, 0);
        rst = 1'b0;

        // R1: idle, random samples, no search started
        cur_req = "R1"; found_num = 0;
        for (int i = 0; i < 40; i++) step(0, rnd_s(), rnd_s());
        chk(found_num == 0, "R1 idle", found_num, 0);

        // R9 / R4 / R8: periodic input, ratio 1 at threshold 1
        new_pattern();
        cur_req = "R4";
        start_search(4, 3);
        for (int i = 0; i < 60; i++) step(0, pat_re[i % 16], pat_im[i % 16]);
        chk(found_at == 36, "R9 found edge", found_at, 36);
        cur_req = "R8";
        for (int i = 0; i < 40; i++) step(0, pat_re[i % 16], pat_im[i % 16]);
        chk(found_num == 1, "R8 single pulse", found_num, 1);

        // R6: threshold 0, first evaluation at index 32
        cur_req = "R6";
        start_search(0, 1);
        for (int i = 0; i < 50; i++) step(0, (i % 5) + 1, -(i % 3) - 1);
        chk(found_at == 34, "R6 first eval", found_at, 34);

        // R7: hold_len 0 acts as 1
        cur_req = "R7";
        start_search(0, 0);
        for (int i = 0; i < 50; i++) step(0, rnd_s() | 1, rnd_s());
        chk(found_at == 34, "R7 hold zero", found_at, 34);

        // R2 / R5: strong samples before and at arm, zeros after
        cur_req = "R2";
        thr = 0; hold = 1;
        for (int i = 0; i < 20; i++) step(0, pat_re[i % 16], pat_im[i % 16]);
        found_at = -1; found_num = 0;
        step(1, 15, 15);
        for (int i = 0; i < 80; i++) step(0, 0, 0);
        chk(found_num == 0, "R2/R5 zero energy", found_num, 0);

        // R5: zero energy with threshold 0 and long hold
        cur_req = "R5";
        start_search(0, 2);
        for (int i = 0; i < 60; i++) step(0, 0, 0);
        chk(found_num == 0, "R5 no hit", found_num, 0);

        // R10: restart during a search
        cur_req = "R10";
        new_pattern();
        start_search(4, 3);
        for (int i = 0; i < 30; i++) step(0, pat_re[i % 16], pat_im[i % 16]);
        found_at = -1; found_num = 0;
        step(1, 0, 0);
        for (int i = 0; i < 60; i++) step(0, pat_re[(i + 5) % 16], pat_im[(i + 5) % 16]);
        chk(found_at == 36, "R10 restart", found_at, 36);

        // R3 / R4 / R7: random thresholds, runs and noisy periodic input
        for (int r = 0; r < 16; r++) begin
            new_pattern();
            cur_req = (r % 2 == 0) ? "R3" : "R7";
            start_search(int'($urandom_range(15)), int'($urandom_range(5)));
            for (int i = 0; i < 140; i++) begin
                int nre = pat_re[i % 16];
                int nim = pat_im[i % 16];
                if ($urandom_range(99) < 12) begin nre = rnd_s(); nim = rnd_s(); end
                if (i > 100) begin nre = rnd_s(); nim = rnd_s(); end
                step(0, nre, nim);
            end
        end

        // R3: pure noise at a high threshold
        cur_req = "R3";
        start_search(3, 4);
        for (int i = 0; i < 200; i++) step(0, rnd_s(), rnd_s());

        step(0, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule